// File: doc/BRIEF.md
# Receive Frame Page Formatter

This block takes one incoming Ethernet frame and writes it into a 2 KB packet page, one byte per clock. The page uses a fixed receive layout. A four-byte header comes first, then the payload, then an optional CRC and a two-byte trailer. A frame starts with a request that carries the frame length, the target page number and the receive configuration. The frame bytes then arrive on a byte stream that has a valid/ready handshake.

Before it writes anything, the block works out the stored size from the length and the configuration. It refuses the frame when receive is off, when soft reset is held, or when the stored size would not fit in a page. Short frames are padded with zeros to the minimum payload. When CRC is kept, a CRC-32 over the padded payload is appended. For a long frame of odd length, the final byte moves into the trailer, after the CRC. When the frame is complete, the block pulses done, reports the stored size and raises a sticky interrupt request.

Top module: `rx_page_formatter`

## Requirements
- R1: A start request with `rx_en` low or `soft_rst` high is refused. No byte is written, no done pulse follows, `rx_irq` stays low and `start_ready` stays high.
- R2: A start request is refused in the same way when the stored size (R4) is above 2048. A stored size of exactly 2048 is accepted.
- R3: Page offsets 0 and 1 hold a 16-bit status word, low byte first. Bit 11 (0x0800) is set when the length is above 1518. Bit 12 (0x1000) is set when the length is odd. All other bits are zero.
- R4: The stored size is 64 for lengths below 64, and otherwise the length rounded down to even. Six is added, and four more when `strip_crc` is low. The size sits at offsets 2 and 3, low byte first, and `done_len` reports the same value.
- R5: The payload starts at offset 4. A frame of 64 bytes or more stores its first length-rounded-down-to-even bytes. A shorter frame stores all its bytes, odd last byte included, then zeros up to 64 payload bytes.
- R6: When `strip_crc` is low, four bytes follow the payload, least significant byte first. They hold the CRC-32 of the effective payload: the reflected polynomial 0xEDB88320, initial value all ones, final inversion. For short frames the effective payload is the 64 padded bytes; otherwise it is every frame byte, including an odd last byte.
- R7: The two last bytes form the trailer. For an odd length of 64 or more they are the frame's last byte, then 0x60. Otherwise (even lengths, and all short frames) they are 0x00, then 0x40.
- R8: Each write lands on address `page_sel*2048 + offset`. Offsets rise by one from 0, and the number of writes equals the stored size.
- R9: `start_ready` drops in the cycle after a start is accepted. `done` is a one-cycle pulse in the cycle after the last trailer byte appears on the write port.
- R10: `rx_irq` is set together with `done` and holds until `irq_ack` is high at a clock edge with no completion. If a completion and `irq_ack` arrive in the same cycle, the set wins.
- R11: While `in_ready` is high and `in_valid` is low, the block waits. No byte is consumed and the stored page is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_valid | input | 1 | Start request for a new frame |
| start_ready | output | 1 | High when a start request can be taken |
| frame_len | input | LEN_W (12) | Frame length in bytes |
| page_sel | input | PAGE_W (2) | Target page number |
| rx_en | input | 1 | Receive enable |
| soft_rst | input | 1 | Soft reset active; frames are refused |
| strip_crc | input | 1 | 1 = store no CRC |
| in_valid | input | 1 | Frame byte valid |
| in_ready | output | 1 | Frame byte accepted when high together with in_valid |
| in_data | input | 8 | Frame byte |
| wr_en | output | 1 | Page memory byte write strobe |
| wr_addr | output | PAGE_W+11 (13) | Page memory byte address |
| wr_data | output | 8 | Page memory byte data |
| done | output | 1 | Frame stored pulse |
| done_len | output | 12 | Stored size of the last frame |
| rx_irq | output | 1 | Receive interrupt request |
| irq_ack | input | 1 | Clears the interrupt request |

## Verification
Two events can meet in one clock edge: the completion of a frame, which sets the interrupt request, and an acknowledge, which clears it. The bench provokes this by holding `irq_ack` high from the start request through the done pulse of a short odd frame. It then expects `rx_irq` high in the done cycle, because the set must win. The bench also checks the plain clear on its own, before every frame.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_HDR,
    S_DATA,
    S_PAD,
    S_CRC,
    S_TRL
  } rxf_state_t;

  localparam logic [31:0] CRC_POLY = 32'hEDB88320;
  localparam int HDR_BYTES = 4;
  localparam int CRC_BYTES = 4;
  localparam int TRL_BYTES = 2;
  localparam logic [7:0] CTRL_EVEN = 8'h40;
  localparam logic [7:0] CTRL_ODD  = 8'h60;

endpackage

// File: rtl/rxf_plan.sv
// Admission and header planning, combinational from the start request.
module rxf_plan #(
  parameter int LEN_W      = 12,
  parameter int PAGE_BYTES = 2048,
  parameter int MIN_LEN    = 64,
  parameter int LONG_LEN   = 1518,
  localparam int SZ_W      = $clog2(PAGE_BYTES) + 1,
  localparam int SUM_W     = LEN_W + 2
) (
  input  logic [LEN_W-1:0] len_i,
  input  logic             rx_en_i,
  input  logic             soft_rst_i,
  input  logic             strip_i,
  output logic             drop_o,
  output logic [SZ_W-1:0]  size_o,
  output logic [15:0]      status_o,
  output logic             short_o,
  output logic             todd_o
);
  import rxf_pkg::*;

  logic [SUM_W-1:0] body_len;
  logic [SUM_W-1:0] total;
  logic             is_long;

  assign short_o  = (len_i < LEN_W'(MIN_LEN));
  assign is_long  = (len_i > LEN_W'(LONG_LEN));
  assign body_len = short_o ? SUM_W'(MIN_LEN) : SUM_W'({len_i[LEN_W-1:1], 1'b0});
  assign total    = body_len + SUM_W'(HDR_BYTES + TRL_BYTES)
                  + (strip_i ? SUM_W'(0) : SUM_W'(CRC_BYTES));

  // R1, R2: refusal conditions
  assign drop_o   = !rx_en_i || soft_rst_i || (total > SUM_W'(PAGE_BYTES));
  assign size_o   = total[SZ_W-1:0];
  // R3: odd flag in bit 12, too-long flag in bit 11
  assign status_o = {3'b000, len_i[0], is_long, 11'h000};
  // R7: odd byte goes to the trailer only for frames not padded
  assign todd_o   = len_i[0] & ~short_o;

endmodule

// File: rtl/rxf_crc.sv
// Byte-wide reflected CRC-32 register; output byte is inverted (R6).
module rxf_crc (
  input  logic       clk,
  input  logic       rst_ni,
  input  logic       init_i,
  input  logic       upd_i,
  input  logic       shift_i,
  input  logic [7:0] din_i,
  output logic [7:0] byte_o
);
  import rxf_pkg::*;

  logic [31:0]      crc_q, crc_d;
  logic [8:0][31:0] stg;

  assign stg[0] = crc_q ^ {24'h000000, din_i};

  generate
    for (genvar k = 0; k < 8; k++) begin : g_bit
      assign stg[k+1] = stg[k][0] ? ((stg[k] >> 1) ^ CRC_POLY) : (stg[k] >> 1);
    end
  endgenerate

  always_comb begin
    crc_d = crc_q;
    if (init_i)       crc_d = '1;
    else if (upd_i)   crc_d = stg[8];
    else if (shift_i) crc_d = {8'hFF, crc_q[31:8]};
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) crc_q <= '1;
    else         crc_q <= crc_d;
  end

  assign byte_o = ~crc_q[7:0];

endmodule

// File: rtl/rxf_wport.sv
// Registered page write port, completion pulse, length and interrupt.
module rxf_wport #(
  parameter int ADDR_W = 13,
  parameter int SZ_W   = 12
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              w_en_i,
  input  logic [ADDR_W-1:0] w_addr_i,
  input  logic [7:0]        w_data_i,
  input  logic              w_last_i,
  input  logic [SZ_W-1:0]   size_i,
  input  logic              irq_ack_i,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [7:0]        wr_data_o,
  output logic              done_o,
  output logic [SZ_W-1:0]   done_len_o,
  output logic              irq_o
);
  logic last_q;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_en_o    <= 1'b0;
      wr_addr_o  <= '0;
      wr_data_o  <= '0;
      last_q     <= 1'b0;
      done_o     <= 1'b0;
      done_len_o <= '0;
      irq_o      <= 1'b0;
    end else begin
      wr_en_o <= w_en_i;
      last_q  <= w_en_i & w_last_i;
      done_o  <= last_q;
      if (w_en_i) begin
        wr_addr_o <= w_addr_i;
        wr_data_o <= w_data_i;
      end
      if (last_q) done_len_o <= size_i;
      // R10: completion sets, acknowledge clears, set wins
      if (last_q)         irq_o <= 1'b1;
      else if (irq_ack_i) irq_o <= 1'b0;
    end
  end

endmodule

// File: rtl/rx_page_formatter.sv
module rx_page_formatter #(
  parameter int  PAGE_BYTES = 2048,
  parameter int  LEN_W      = 12,
  parameter int  PAGE_W     = 2,
  parameter int  MIN_LEN    = 64,
  parameter int  LONG_LEN   = 1518,
  localparam int OFS_W      = $clog2(PAGE_BYTES),
  localparam int SZ_W       = OFS_W + 1,
  localparam int ADDR_W     = PAGE_W + OFS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_valid,
  output logic              start_ready,
  input  logic [LEN_W-1:0]  frame_len,
  input  logic [PAGE_W-1:0] page_sel,
  input  logic              rx_en,
  input  logic              soft_rst,
  input  logic              strip_crc,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [7:0]        in_data,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data,
  output logic              done,
  output logic [SZ_W-1:0]   done_len,
  output logic              rx_irq,
  input  logic              irq_ack
);
  import rxf_pkg::*;

  localparam logic [OFS_W-1:0] PAD_END = OFS_W'(HDR_BYTES + MIN_LEN - 1);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rs_q;
  logic       rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_ni = rs_q[1];

  // planning
  logic             p_drop, p_short, p_todd;
  logic [SZ_W-1:0]  p_size;
  logic [15:0]      p_status;

  rxf_plan #(
    .LEN_W(LEN_W), .PAGE_BYTES(PAGE_BYTES), .MIN_LEN(MIN_LEN), .LONG_LEN(LONG_LEN)
  ) u_plan (
    .len_i(frame_len), .rx_en_i(rx_en), .soft_rst_i(soft_rst), .strip_i(strip_crc),
    .drop_o(p_drop), .size_o(p_size), .status_o(p_status),
    .short_o(p_short), .todd_o(p_todd)
  );

  // frame context, loaded on acceptance
  logic              lat_en;
  logic [LEN_W-1:0]  len_q;
  logic [PAGE_W-1:0] page_q;
  logic [SZ_W-1:0]   size_q;
  logic [15:0]       status_q;
  logic              keep_q, short_q, todd_q;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      len_q    <= '0;
      page_q   <= '0;
      size_q   <= '0;
      status_q <= '0;
      keep_q   <= 1'b0;
      short_q  <= 1'b0;
      todd_q   <= 1'b0;
    end else if (lat_en) begin
      len_q    <= frame_len;
      page_q   <= page_sel;
      size_q   <= p_size;
      status_q <= p_status;
      keep_q   <= ~strip_crc;
      short_q  <= p_short;
      todd_q   <= p_todd;
    end
  end

  // sequencer state
  rxf_state_t       st_q, st_d;
  logic [OFS_W-1:0] ofs_q, ofs_d;
  logic [LEN_W-1:0] bcnt_q, bcnt_d;
  logic [1:0]       sub_q, sub_d;
  logic [7:0]       last_q, last_d;

  logic             crc_init, crc_upd, crc_shift;
  logic [7:0]       crc_din, crc_byte;
  logic             w_en, w_last;
  logic [7:0]       w_data;
  logic [15:0]      size16;
  logic             is_last;

  assign size16  = 16'(size_q);
  assign is_last = (bcnt_q == len_q - LEN_W'(1));

  rxf_crc u_crc (
    .clk(clk), .rst_ni(rst_ni), .init_i(crc_init), .upd_i(crc_upd),
    .shift_i(crc_shift), .din_i(crc_din), .byte_o(crc_byte)
  );

  always_comb begin
    st_d      = st_q;
    ofs_d     = ofs_q;
    bcnt_d    = bcnt_q;
    sub_d     = sub_q;
    last_d    = last_q;
    lat_en    = 1'b0;
    crc_init  = 1'b0;
    crc_upd   = 1'b0;
    crc_shift = 1'b0;
    crc_din   = 8'h00;
    w_en      = 1'b0;
    w_last    = 1'b0;
    w_data    = 8'h00;
    unique case (st_q)
      S_IDLE: begin
        if (start_valid && !p_drop) begin
          lat_en   = 1'b1;
          crc_init = 1'b1;
          ofs_d    = '0;
          bcnt_d   = '0;
          st_d     = S_HDR;
        end
      end
      S_HDR: begin
        w_en  = 1'b1;
        ofs_d = ofs_q + OFS_W'(1);
        unique case (ofs_q[1:0])
          2'd0:    w_data = status_q[7:0];
          2'd1:    w_data = status_q[15:8];
          2'd2:    w_data = size16[7:0];
          default: w_data = size16[15:8];
        endcase
        if (ofs_q[1:0] == 2'd3) st_d = (len_q == '0) ? S_PAD : S_DATA;
      end
      S_DATA: begin
        sub_d = 2'd0;
        if (in_valid) begin
          crc_upd = 1'b1;
          crc_din = in_data;
          last_d  = in_data;
          bcnt_d  = bcnt_q + LEN_W'(1);
          if (!(is_last && todd_q)) begin
            w_en   = 1'b1;
            w_data = in_data;
            ofs_d  = ofs_q + OFS_W'(1);
          end
          if (is_last) st_d = short_q ? S_PAD : (keep_q ? S_CRC : S_TRL);
        end
      end
      S_PAD: begin
        sub_d   = 2'd0;
        w_en    = 1'b1;
        crc_upd = 1'b1;
        ofs_d   = ofs_q + OFS_W'(1);
        if (ofs_q == PAD_END) st_d = keep_q ? S_CRC : S_TRL;
      end
      S_CRC: begin
        w_en      = 1'b1;
        w_data    = crc_byte;
        crc_shift = 1'b1;
        ofs_d     = ofs_q + OFS_W'(1);
        sub_d     = sub_q + 2'd1;
        if (sub_q == 2'd3) st_d = S_TRL;
      end
      S_TRL: begin
        w_en  = 1'b1;
        ofs_d = ofs_q + OFS_W'(1);
        sub_d = sub_q + 2'd1;
        if (sub_q == 2'd0) begin
          w_data = todd_q ? last_q : 8'h00;
        end else begin
          w_data = todd_q ? CTRL_ODD : CTRL_EVEN;
          w_last = 1'b1;
          st_d   = S_IDLE;
        end
      end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= S_IDLE;
      ofs_q  <= '0;
      bcnt_q <= '0;
      sub_q  <= '0;
      last_q <= '0;
    end else begin
      st_q   <= st_d;
      ofs_q  <= ofs_d;
      bcnt_q <= bcnt_d;
      sub_q  <= sub_d;
      last_q <= last_d;
    end
  end

  assign start_ready = (st_q == S_IDLE);
  assign in_ready    = (st_q == S_DATA);

  rxf_wport #(.ADDR_W(ADDR_W), .SZ_W(SZ_W)) u_wport (
    .clk(clk), .rst_ni(rst_ni),
    .w_en_i(w_en), .w_addr_i({page_q, ofs_q}), .w_data_i(w_data),
    .w_last_i(w_last), .size_i(size_q), .irq_ack_i(irq_ack),
    .wr_en_o(wr_en), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
    .done_o(done), .done_len_o(done_len), .irq_o(rx_irq)
  );

endmodule

// File: rtl/rxf_checker.sv
module rxf_checker #(
  parameter int SZ_W       = 12,
  parameter int PAGE_BYTES = 2048,
  parameter int MIN_LEN    = 64
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start_valid,
  input logic            start_ready,
  input logic            rx_en,
  input logic            soft_rst,
  input logic            in_valid,
  input logic            in_ready,
  input logic            wr_en,
  input logic [7:0]      wr_data,
  input logic            done,
  input logic [SZ_W-1:0] done_len,
  input logic            rx_irq,
  input logic            irq_ack
);

  assert_refuse_cfg_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (start_valid && start_ready && (!rx_en || soft_rst)) |=> (start_ready && !wr_en));

  assert_size_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (done_len >= SZ_W'(MIN_LEN + 6)) && (done_len <= SZ_W'(PAGE_BYTES)) && !done_len[0]);

  assert_trailer_ctrl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(wr_en) && ($past(wr_data) == 8'h40 || $past(wr_data) == 8'h60));

  assert_busy_after_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(start_ready) |-> $past(start_valid));

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_irq_with_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> rx_irq);

  assert_irq_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_irq && !irq_ack) |=> rx_irq);

  assert_stall_wait_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && !in_valid) |=> in_ready);

endmodule

bind rx_page_formatter rxf_checker #(
  .SZ_W(SZ_W), .PAGE_BYTES(PAGE_BYTES), .MIN_LEN(MIN_LEN)
) u_rxf_chk (
  .clk(clk), .rst_n(rst_n), .start_valid(start_valid), .start_ready(start_ready),
  .rx_en(rx_en), .soft_rst(soft_rst), .in_valid(in_valid), .in_ready(in_ready),
  .wr_en(wr_en), .wr_data(wr_data), .done(done), .done_len(done_len),
  .rx_irq(rx_irq), .irq_ack(irq_ack)
);

// File: tb/test_rx_page_formatter.sv
`timescale 1ns/1ps
module test_rx_page_formatter;
  localparam int LEN_W  = 12;
  localparam int PAGE_W = 2;
  localparam int OFS_W  = 11;
  localparam int ADDR_W = PAGE_W + OFS_W;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              start_valid, start_ready;
  logic [LEN_W-1:0]  frame_len;
  logic [PAGE_W-1:0] page_sel;
  logic              rx_en, soft_rst, strip_crc;
  logic              in_valid, in_ready;
  logic [7:0]        in_data;
  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr;
  logic [7:0]        wr_data;
  logic              done;
  logic [11:0]       done_len;
  logic              rx_irq, irq_ack;

  always #4 clk = ~clk;

  rx_page_formatter i_rx_page_formatter (
    .clk(clk), .rst_n(rst_n), .start_valid(start_valid), .start_ready(start_ready),
    .frame_len(frame_len), .page_sel(page_sel), .rx_en(rx_en), .soft_rst(soft_rst),
    .strip_crc(strip_crc), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .done(done),
    .done_len(done_len), .rx_irq(rx_irq), .irq_ack(irq_ack)
  );

  int n_chk = 0;
  int n_bad = 0;
  int wr_cnt, order_err, page_err, exp_page;
  logic [7:0] fbuf [2048];
  logic [7:0] pbuf [2048];
  logic [7:0] exp_img [2048];
  logic [7:0] got [2048];

  task automatic check(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  // write monitor
  always @(negedge clk) begin
    if (wr_en === 1'b1) begin
      if (int'(wr_addr[ADDR_W-1:OFS_W]) != exp_page) page_err++;
      if (int'(wr_addr[OFS_W-1:0]) != wr_cnt) order_err++;
      got[wr_addr[OFS_W-1:0]] = wr_data;
      wr_cnt++;
    end
  end

  function automatic logic [31:0] ref_crc(input int n);
    logic [31:0] c;
    c = 32'hFFFFFFFF;
    for (int i = 0; i < n; i++)
      for (int b = 0; b < 8; b++) begin
        bit fb;
        fb = c[0] ^ pbuf[i][b];
        c = c >> 1;
        if (fb) c = c ^ 32'hEDB88320;
      end
    return ~c;
  endfunction

  task automatic cmp_region(input int lo, input int hi, input string what);
    int bad;
    bad = -1;
    for (int k = lo; k < hi; k++)
      if (got[k] !== exp_img[k] && bad < 0) bad = k;
    if (bad < 0) check(1'b1, what, 0, 0);
    else check(1'b0, $sformatf("%s at offset %0d", what, bad), 32'(got[bad]), 32'(exp_img[bad]));
  endtask

  task automatic irq_clear();
    @(negedge clk); irq_ack = 1'b1;
    @(negedge clk); irq_ack = 1'b0;
    check(rx_irq == 1'b0, "R10 acknowledge clears rx_irq", 32'(rx_irq), 0);
  endtask

  task automatic run_frame(input int len, input int page, input bit keep,
                           input bit gaps, input bit ack_hold, input string name);
    int ev, effp, sz, o, cyc, lim, i;
    logic [31:0] c;
    logic [15:0] st;
    irq_clear();
    for (int k = 0; k < len; k++) fbuf[k] = 8'((k * 37) + (len * 11) + 5);
    effp = (len < 64) ? 64 : len;
    ev   = (len < 64) ? 64 : (len & ~1);
    for (int k = 0; k < effp; k++) pbuf[k] = (k < len) ? fbuf[k] : 8'h00;
    sz = ev + 6 + (keep ? 4 : 0);
    st = 16'h0000;
    if (len > 1518) st = st | 16'h0800;
    if (len % 2)    st = st | 16'h1000;
    exp_img[0] = st[7:0];
    exp_img[1] = st[15:8];
    exp_img[2] = 8'(sz);
    exp_img[3] = 8'(sz >> 8);
    for (int k = 0; k < ev; k++) exp_img[4 + k] = pbuf[k];
    o = 4 + ev;
    if (keep) begin
      c = ref_crc(effp);
      for (int k = 0; k < 4; k++) exp_img[o + k] = 8'(c >> (8 * k));
      o = o + 4;
    end
    if (effp % 2) begin exp_img[o] = pbuf[effp - 1]; exp_img[o + 1] = 8'h60; end
    else          begin exp_img[o] = 8'h00;          exp_img[o + 1] = 8'h40; end
    for (int k = 0; k < 2048; k++) got[k] = 8'hxx;
    wr_cnt = 0; order_err = 0; page_err = 0; exp_page = page;

    @(negedge clk);
    start_valid = 1'b1; frame_len = LEN_W'(len); page_sel = PAGE_W'(page);
    rx_en = 1'b1; soft_rst = 1'b0; strip_crc = !keep; irq_ack = ack_hold;
    @(negedge clk);
    start_valid = 1'b0;
    check(start_ready == 1'b0, {"R9 start_ready low after accept: ", name}, 32'(start_ready), 0);

    i = 0; cyc = 0;
    while (i < len) begin
      if (gaps && (cyc % 3 == 2)) begin
        in_valid = 1'b0;
      end else begin
        in_valid = 1'b1;
        in_data  = fbuf[i];
        if (in_ready) i++;
      end
      cyc++;
      @(negedge clk);
    end
    in_valid = 1'b0;

    lim = 0;
    while (done !== 1'b1 && lim < 4000) begin @(negedge clk); lim++; end
    check(done === 1'b1, {"R9 done pulse seen: ", name}, 32'(done), 1);
    check(32'(done_len) == 32'(sz), {"R4 done_len: ", name}, 32'(done_len), 32'(sz));
    check(rx_irq == 1'b1, {"R10 rx_irq set with done: ", name}, 32'(rx_irq), 1);
    irq_ack = 1'b0;
    cmp_region(0, 2, {"R3 status word: ", name});
    cmp_region(2, 4, {"R4 size field: ", name});
    cmp_region(4, 4 + ev, {"R5 payload: ", name});
    if (keep) cmp_region(4 + ev, 8 + ev, {"R6 crc bytes: ", name});
    cmp_region(sz - 2, sz, {"R7 trailer: ", name});
    check(wr_cnt == sz && order_err == 0 && page_err == 0, {"R8 write count/address: ", name},
          32'(wr_cnt + 4096 * (order_err + page_err)), 32'(sz));
    @(negedge clk);
    check(done == 1'b0, {"R9 done is one cycle: ", name}, 32'(done), 0);
    check(rx_irq == 1'b1, {"R10 rx_irq held: ", name}, 32'(rx_irq), 1);
  endtask

  task automatic refuse(input int len, input bit en, input bit srst, input bit keep, input string tag);
    bit ok_rdy, ok_wr, ok_done;
    irq_clear();
    wr_cnt = 0; ok_rdy = 1; ok_wr = 1; ok_done = 1;
    @(negedge clk);
    start_valid = 1'b1; frame_len = LEN_W'(len); page_sel = '0;
    rx_en = en; soft_rst = srst; strip_crc = !keep;
    @(negedge clk);
    start_valid = 1'b0;
    for (int k = 0; k < 20; k++) begin
      if (start_ready !== 1'b1) ok_rdy = 0;
      if (in_ready !== 1'b0) ok_rdy = 0;
      if (done !== 1'b0) ok_done = 0;
      @(negedge clk);
    end
    ok_wr = (wr_cnt == 0);
    check(ok_rdy, {tag, " refused: start_ready stays high"}, 32'(ok_rdy), 1);
    check(ok_wr, {tag, " refused: no writes"}, 32'(wr_cnt), 0);
    check(ok_done && rx_irq == 1'b0, {tag, " refused: no done, no rx_irq"}, 32'(rx_irq), 0);
    rx_en = 1'b1; soft_rst = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start_valid = 1'b0; frame_len = '0; page_sel = '0;
    rx_en = 1'b0; soft_rst = 1'b0; strip_crc = 1'b0; in_valid = 1'b0;
    in_data = '0; irq_ack = 1'b0; exp_page = 0; wr_cnt = 0; order_err = 0; page_err = 0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(start_ready == 1'b1 && in_ready == 1'b0, "R9 reset: idle and ready", 32'({start_ready, in_ready}), 32'h2);
    check(wr_en == 1'b0 && done == 1'b0, "R8 reset: no write, no done", 32'({wr_en, done}), 0);
    check(rx_irq == 1'b0, "R10 reset: rx_irq low", 32'(rx_irq), 0);

    run_frame(100,  1, 1, 0, 0, "long even, crc kept");
    run_frame(101,  2, 0, 0, 0, "long odd, crc stripped");
    run_frame(33,   0, 1, 0, 1, "short odd, ack held through done");
    run_frame(0,    3, 0, 0, 0, "empty frame");
    run_frame(64,   0, 0, 0, 0, "exact minimum");
    run_frame(70,   1, 1, 1, 0, "R11 stalled input");
    run_frame(1601, 2, 1, 0, 0, "too-long odd");
    run_frame(2039, 3, 1, 0, 0, "R2 size exactly 2048");
    refuse(2040, 1, 0, 1, "R2 size 2050");
    refuse(100, 0, 0, 1, "R1 receive off");
    refuse(100, 1, 1, 0, "R1 soft reset");
    run_frame(65, 1, 1, 0, 0, "after refusals");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule